// File: doc/BRIEF.md
# PWM Time-Base Counter with Double-Buffered Period

This block is the timing core of a pulse-width modulator. It holds a 16-bit up-counter that advances by one on each cycle where the time-base enable is high. When the counter reaches the active period value, the next enable returns it to zero. One PWM cycle is therefore the active period plus one enabled tick. On every enabled cycle in which the counter is zero, a one-cycle zero strobe goes out to the comparison and output logic downstream.

Software reaches the block through a single-cycle register bus. Writes are qualified by a write enable, and read data is combinational from the address. The counter can be read and written directly. A counter write takes effect on the next bus clock edge and ignores the time-base enable. The period can be double-buffered, under the control of one mode bit. While buffering is on, a period access goes to a holding copy, and that copy moves into the active period only at a counter zero. While buffering is off, a period access reaches the active period directly.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the counter, both period copies and the mode bit are zero, so a read at every address returns 0.
- R2: With no counter write, the counter increments by one on each cycle where `tbEn` is high, and holds its value while `tbEn` is low.
- R3: When `tbEn` is high and the counter equals the active period, the counter becomes 0 on that edge. A counter above the active period keeps counting and wraps from 0xFFFF to 0.
- R4: `zeroStrobe` is high in exactly those cycles where `tbEn` is high and the counter is 0.
- R5: A bus write at address 0 loads the counter on that clock edge, even if `tbEn` is high in the same cycle.
- R6: With the mode bit at 0, reads and writes at address 1 reach the holding copy, and a write there leaves the active period unchanged until the next zero.
- R7: With the mode bit at 0, the active period takes the holding copy on each cycle that raises `zeroStrobe`. If a holding write falls in that cycle, the active period takes the previous holding value, and the new value is transferred at the following zero.
- R8: With the mode bit at 1, reads and writes at address 1 reach the active period, and a write there governs the wrap from the next cycle on.
- R9: The mode bit is bit 0 of address 2. It can be written and read back there, and addresses 2 and 3 return 0 in all other bits.
- R10: A read at address 0 returns the live counter value, the same as `cntOut`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rstN | input | 1 | Active-low synchronous reset |
| tbEn | input | 1 | Time-base tick enable |
| busWe | input | 1 | Register write enable |
| busAddr | input | 2 | Register address: 0 counter, 1 period, 2 mode |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Combinational read data for `busAddr` |
| cntOut | output | 16 | Current counter value |
| zeroStrobe | output | 1 | One-cycle pulse on an enabled tick at counter zero |

## Verification
The hardest case to reach from the ports is a holding-copy write that lands in the same cycle as a zero-triggered transfer. In that case the active period must take the old holding value, and no port shows the active period directly. The stimulus first parks the counter at zero with a known holding value. It then writes a new period together with an enabled tick. The bench then counts ticks up to the next wrap, because the wrap point is the only visible sign of which value became active. A second wrap confirms that the new value arrives one zero later. A counter write set above the period, followed by the counter overflowing through 0xFFFF, covers the wrap that bypasses the period match.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PRD  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd2;

  // One-hot-ish strobe bundle from control to datapath
  typedef struct packed {
    logic cntLoad;     // bus write replaces the counter
    logic cntClear;    // period match on an enabled tick
    logic cntStep;     // ordinary increment on an enabled tick
    logic shadowWr;    // bus write into the holding period copy
    logic activeWr;    // bus write straight into the active period
    logic activeLoad;  // holding copy transferred at counter zero
  } tbStrobes_t;

endpackage

// File: rtl/pwm_tb_ctrl.sv
module pwm_tb_ctrl
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tbEn,
  input  logic                busWe,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [CNT_W-1:0]    busWdata,
  input  logic [CNT_W-1:0]    cnt,
  input  logic [CNT_W-1:0]    activePrd,
  input  logic [CNT_W-1:0]    shadowPrd,
  output tbStrobes_t          strobes,
  output logic                zeroHit,
  output logic [CNT_W-1:0]    rdata
);

  logic directLoad;
  logic wrCnt;
  logic wrPrd;
  logic wrMode;
  logic atZero;
  logic atPeriod;

  assign wrCnt    = busWe && (busAddr == ADDR_CNT);
  assign wrPrd    = busWe && (busAddr == ADDR_PRD);
  assign wrMode   = busWe && (busAddr == ADDR_MODE);
  assign atZero   = (cnt == '0);
  assign atPeriod = (cnt == activePrd);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      directLoad <= 1'b0;
    end else if (wrMode) begin
      directLoad <= busWdata[0];
    end
  end

  always_comb begin
    zeroHit            = tbEn && atZero;
    strobes.cntLoad    = wrCnt;
    strobes.cntClear   = !wrCnt && tbEn && atPeriod;
    strobes.cntStep    = !wrCnt && tbEn && !atPeriod;
    strobes.shadowWr   = wrPrd && !directLoad;
    strobes.activeWr   = wrPrd && directLoad;
    strobes.activeLoad = tbEn && atZero && !directLoad;
  end

  always_comb begin
    unique case (busAddr)
      ADDR_CNT:  rdata = cnt;
      ADDR_PRD:  rdata = directLoad ? activePrd : shadowPrd;
      ADDR_MODE: rdata = {{(CNT_W-1){1'b0}}, directLoad};
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/pwm_tb_dp.sv
module pwm_tb_dp
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tbStrobes_t       strobes,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] activePrd,
  output logic [CNT_W-1:0] shadowPrd
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobes.cntLoad) begin
      cnt <= wdata;
    end else if (strobes.cntClear) begin
      cnt <= '0;
    end else if (strobes.cntStep) begin
      cnt <= cnt + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowPrd <= '0;
    end else if (strobes.shadowWr) begin
      shadowPrd <= wdata;
    end
  end

  // Transfer reads the pre-edge holding value, so a coincident write waits a period
  always_ff @(posedge clk) begin
    if (!rstN) begin
      activePrd <= '0;
    end else if (strobes.activeWr) begin
      activePrd <= wdata;
    end else if (strobes.activeLoad) begin
      activePrd <= shadowPrd;
    end
  end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tbEn,
  input  logic              busWe,
  input  logic [1:0]        busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  output logic [CNT_W-1:0]  cntOut,
  output logic              zeroStrobe
);

  tbStrobes_t       strobes;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] activePrd;
  logic [CNT_W-1:0] shadowPrd;

  pwm_tb_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tbEn      (tbEn),
    .busWe     (busWe),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .cnt       (cnt),
    .activePrd (activePrd),
    .shadowPrd (shadowPrd),
    .strobes   (strobes),
    .zeroHit   (zeroStrobe),
    .rdata     (busRdata)
  );

  pwm_tb_dp #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wdata     (busWdata),
    .cnt       (cnt),
    .activePrd (activePrd),
    .shadowPrd (shadowPrd)
  );

  assign cntOut = cnt;

endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tbEn,
  input logic             busWe,
  input logic [1:0]       busAddr,
  input logic [CNT_W-1:0] busWdata,
  input logic [CNT_W-1:0] busRdata,
  input logic [CNT_W-1:0] cntOut,
  input logic             zeroStrobe
);

  logic cntWr;
  assign cntWr = busWe && (busAddr == 2'd0);

  AST_CNT_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    cntWr |=> cntOut == $past(busWdata)); // R5

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!tbEn && !cntWr) |=> $stable(cntOut)); // R2

  AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (tbEn && !cntWr) |=> (cntOut == $past(cntOut) + 1'b1) || (cntOut == '0)); // R3

  AST_ZERO_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (zeroStrobe && !cntWr) |=> cntOut <= 1); // R4

  AST_ZERO_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    zeroStrobe |-> tbEn); // R4

  AST_LIVE_READ: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd0) |-> busRdata == cntOut); // R10

  AST_MODE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[1]) |-> busRdata[CNT_W-1:1] == '0); // R9

endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .tbEn       (tbEn),
  .busWe      (busWe),
  .busAddr    (busAddr),
  .busWdata   (busWdata),
  .busRdata   (busRdata),
  .cntOut     (cntOut),
  .zeroStrobe (zeroStrobe)
);

// File: tb/pwm_timebase_bench.sv
module pwm_timebase_bench;

  typedef struct packed {
    logic [7:0]  req;
    logic        we;
    logic [1:0]  addr;
    logic [15:0] data;
    logic        en;
    logic        expZ;
    logic [15:0] expRd;
    logic [15:0] expCnt;
  } vec_t;

  localparam int NV = 20;

  // Columns: req, we, addr, data, en, expZ, expRd (before edge), expCnt (after edge)
  localparam vec_t VECS [NV] = '{
    '{8'd6,  1'b1, 2'd1, 16'h0003, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R6 holding write, no tick
    '{8'd7,  1'b0, 2'd1, 16'h0000, 1'b1, 1'b1, 16'h0003, 16'h0000}, // R7 zero moves 3 to active; old active 0 wraps
    '{8'd4,  1'b0, 2'd0, 16'h0000, 1'b1, 1'b1, 16'h0000, 16'h0001}, // R4 strobe at zero
    '{8'd2,  1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 16'h0001, 16'h0002}, // R2 count
    '{8'd2,  1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 16'h0002, 16'h0002}, // R2 hold without enable
    '{8'd10, 1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 16'h0002, 16'h0003}, // R10 live read
    '{8'd3,  1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 16'h0003, 16'h0000}, // R3 wrap at period 3
    '{8'd7,  1'b1, 2'd1, 16'h0005, 1'b1, 1'b1, 16'h0003, 16'h0001}, // R7 coincident holding write
    '{8'd6,  1'b0, 2'd1, 16'h0000, 1'b1, 1'b0, 16'h0005, 16'h0002}, // R6 holding reads 5
    '{8'd7,  1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 16'h0002, 16'h0003}, // R7
    '{8'd7,  1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 16'h0003, 16'h0000}, // R7 active was old value 3
    '{8'd7,  1'b0, 2'd0, 16'h0000, 1'b1, 1'b1, 16'h0000, 16'h0001}, // R7 now 5 transfers
    '{8'd5,  1'b1, 2'd0, 16'h0009, 1'b1, 1'b0, 16'h0001, 16'h0009}, // R5 write beats tick
    '{8'd3,  1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 16'h0009, 16'h000A}, // R3 above period keeps counting
    '{8'd5,  1'b1, 2'd0, 16'hFFFF, 1'b0, 1'b0, 16'h000A, 16'hFFFF}, // R5 write without tick
    '{8'd3,  1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 16'hFFFF, 16'h0000}, // R3 overflow wrap
    '{8'd9,  1'b1, 2'd2, 16'h0001, 1'b1, 1'b1, 16'h0000, 16'h0001}, // R9 set direct mode
    '{8'd8,  1'b1, 2'd1, 16'h0002, 1'b1, 1'b0, 16'h0005, 16'h0002}, // R8 read active, write 2
    '{8'd8,  1'b0, 2'd1, 16'h0000, 1'b1, 1'b0, 16'h0002, 16'h0000}, // R8 wrap at new 2
    '{8'd9,  1'b0, 2'd2, 16'h0000, 1'b1, 1'b1, 16'h0001, 16'h0001}  // R9 mode reads back
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        tbEn;
  logic        busWe;
  logic [1:0]  busAddr;
  logic [15:0] busWdata;
  logic [15:0] busRdata;
  logic [15:0] cntOut;
  logic        zeroStrobe;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  pwm_timebase u_pwm_timebase (
    .clk        (clk),
    .rstN       (rstN),
    .tbEn       (tbEn),
    .busWe      (busWe),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .cntOut     (cntOut),
    .zeroStrobe (zeroStrobe)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readAt(input logic [1:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    busWe = 1'b0; tbEn = 1'b0; busAddr = a;
    #1 check(tag, busRdata, exp);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; busWe = 1'b0; tbEn = 1'b0; busAddr = 2'd0; busWdata = '0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    rstN = 1'b0; tbEn = 1'b0; busWe = 1'b0; busAddr = 2'd0; busWdata = '0;
    doReset();
    // R1 reset state
    readAt(2'd0, 16'h0, "R1 counter");
    readAt(2'd1, 16'h0, "R1 period");
    readAt(2'd2, 16'h0, "R1 mode");
    check("R1 cntOut", cntOut, 16'h0);
    check("R4 no strobe without enable", {15'd0, zeroStrobe}, 16'h0);
    readAt(2'd3, 16'h0, "R9 unused address");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      busWe = VECS[i].we; busAddr = VECS[i].addr;
      busWdata = VECS[i].data; tbEn = VECS[i].en;
      #1;
      check($sformatf("R%0d vec%0d strobe", VECS[i].req, i), {15'd0, zeroStrobe}, {15'd0, VECS[i].expZ});
      check($sformatf("R%0d vec%0d rdata", VECS[i].req, i), busRdata, VECS[i].expRd);
      @(posedge clk); #1;
      check($sformatf("R%0d vec%0d count", VECS[i].req, i), cntOut, VECS[i].expCnt);
    end

    // R6 holding write in buffered mode must not change the wrap point before zero
    doReset();
    @(negedge clk); busWe = 1'b1; busAddr = 2'd0; busWdata = 16'h0004; tbEn = 1'b0;
    @(negedge clk); busWe = 1'b1; busAddr = 2'd1; busWdata = 16'h0002; tbEn = 1'b1;
    @(posedge clk); #1 check("R6 count runs past written value", cntOut, 16'h0005);

    // R1 mid-run reset clears mode and period
    doReset();
    readAt(2'd2, 16'h0, "R1 mode after reset");
    readAt(2'd1, 16'h0, "R1 period after reset");
    readAt(2'd0, 16'h0, "R1 counter after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule